// File: doc/BRIEF.md
# Cascaded-Timer Traffic Light Sequencer

This block drives the lamps of a two-way road junction from three on-delay timers joined in a ring. The first timer sets the length of the north/south red phase, the second the north/south green phase and the third the north/south amber phase. Each timer is enabled by the done flag of the timer before it. The done flag of the last timer clears the whole chain, so the sequence repeats without end. The east/west lamps come from the same timers: east/west is green and then amber while north/south is red, and red in every other phase.

Time is counted in ticks. A tick is a one-clock pulse at the time base, which is one second in normal use and is supplied from outside. The three presets are parameters of up to 16 bits, so the same block can also build long delays of tens of thousands of ticks. A synchronous reset clears all timers and restarts the first phase.

Top module: `traffic_cascade`

## Requirements
- R1: While `rst` is high at a rising clock edge, all timers clear. From the next cycle the lamps show north/south red and east/west green, and the first phase starts counting from zero.
- R2: North/south runs red for `RED_T` ticks, then green for `GREEN_T` ticks, then amber for `AMBER_T` ticks, then red again. A phase changes in the cycle after the edge that samples its final tick.
- R3: An accumulator advances only on edges where `tick` is high. With no ticks, the lamps hold their state indefinitely.
- R4: When amber ends, the chain spends exactly one clock in a restart cycle. In that cycle the lamps show north/south red and east/west green, and any tick is ignored. The red phase then needs a full `RED_T` further ticks.
- R5: During the first `RED_T - AMBER_T` ticks of the north/south red phase, east/west is green. During the last `AMBER_T` ticks it is amber. While north/south is green or amber, east/west is red.
- R6: In every cycle, each direction shows exactly one of red, amber and green. The two directions are never both non-red.
- R7: The presets are 16 bits wide. A red preset above 16383 and a green preset of 12000, with a tick on every clock, give phase lengths of exactly those numbers of clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock pulse at the timer time base |
| ns_red | output | 1 | North/south red lamp |
| ns_amber | output | 1 | North/south amber lamp |
| ns_green | output | 1 | North/south green lamp |
| ew_red | output | 1 | East/west red lamp |
| ew_amber | output | 1 | East/west amber lamp |
| ew_green | output | 1 | East/west green lamp |

## Verification
The sequencer is driven in four ways. A tick on every clock checks exact phase lengths and shows that a tick in the restart cycle is ignored. A tick on every third clock and an irregular burst pattern separate counting ticks from counting clocks. A long stretch with no ticks shows that all state is held. A reset in the middle of the green phase confirms that the sequence restarts from the first phase. A second instance with 16-bit presets and a permanent tick runs a red phase of 20000 clocks and a green phase of 12000 clocks, which exposes any truncation of the accumulator width.

// File: rtl/traffic_cascade.sv
`timescale 1ns/1ps
module traffic_cascade #(
  parameter int W = 16,
  parameter logic [W-1:0] RED_T   = 30,
  parameter logic [W-1:0] GREEN_T = 25,
  parameter logic [W-1:0] AMBER_T = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic ns_red,
  output logic ns_amber,
  output logic ns_green,
  output logic ew_red,
  output logic ew_amber,
  output logic ew_green
);

  localparam logic [W-1:0] EW_GO = RED_T - AMBER_T;

  function automatic logic [W-1:0] preset_of(input int idx);
    case (idx)
      0:       return RED_T;
      1:       return GREEN_T;
      default: return AMBER_T;
    endcase
  endfunction

  logic [W-1:0] acc [3];
  logic [2:0]   dn;
  logic [2:0]   en;
  logic         restart;

  // ring: each stage enabled by the previous done, last done clears all
  assign restart = dn[2];
  assign en[0]   = ~restart;
  assign en[1]   = ~restart & dn[0];
  assign en[2]   = ~restart & dn[1];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (rst || !en[i]) begin
        acc[i] <= '0;
        dn[i]  <= 1'b0;
      end else begin
        if (tick && acc[i] != preset_of(i))
          acc[i] <= acc[i] + 1'b1;
        dn[i] <= (acc[i] == preset_of(i)) ||
                 (tick && (acc[i] + 1'b1) == preset_of(i));
      end
    end
  end

  logic ph_red, ph_green, ph_amber;
  assign ph_red   = restart | ~dn[0];
  assign ph_green = ~restart & dn[0] & ~dn[1];
  assign ph_amber = dn[1] & ~dn[2];

  assign ns_red   = ph_red;
  assign ns_green = ph_green;
  assign ns_amber = ph_amber;

  assign ew_green = ph_red & (restart | (acc[0] < EW_GO));
  assign ew_amber = ph_red & ~restart & (acc[0] >= EW_GO);
  assign ew_red   = ~ph_red;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ns_red && ew_green && dn == 3'b000 && acc[0] == '0)); // R1
  AST_RED_TO_GREEN: assert property (@(posedge clk) disable iff (rst)
    $fell(ns_red) |-> ns_green); // R2
  AST_AMBER_TO_RED: assert property (@(posedge clk) disable iff (rst)
    ($rose(ns_red) && !$past(rst)) |-> $past(ns_amber)); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> (acc[0] == $past(acc[0]) && acc[1] == $past(acc[1]))); // R3
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
    (acc[0] <= RED_T && acc[1] <= GREEN_T && acc[2] <= AMBER_T)); // R3
  AST_RESTART_SHORT: assert property (@(posedge clk) disable iff (rst)
    restart |=> !restart); // R4
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> (acc[0] == '0 && dn[0] == 1'b0)); // R4
  AST_EW_RED_WHEN_NS_GO: assert property (@(posedge clk) disable iff (rst)
    (ns_green || ns_amber) |-> ew_red); // R5
  AST_NS_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
    $onehot({ns_red, ns_amber, ns_green})); // R6
  AST_EW_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
    $onehot({ew_red, ew_amber, ew_green})); // R6
  AST_NO_CROSS_GO: assert property (@(posedge clk) disable iff (rst)
    (ns_red || ew_red)); // R6

endmodule

// File: tb/traffic_cascade_bench.sv
`timescale 1ns/1ps
module traffic_cascade_bench;
  localparam int RED = 30, GREEN = 25, AMBER = 5;
  localparam int L_RED = 20000, L_GREEN = 12000, L_AMBER = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic rst_long = 1'b1;
  logic ns_red, ns_amber, ns_green, ew_red, ew_amber, ew_green;
  logic l_ns_red, l_ns_amber, l_ns_green, l_ew_red, l_ew_amber, l_ew_green;

  always #2 clk = ~clk;

  traffic_cascade u_traffic_cascade (
    .clk(clk), .rst(rst), .tick(tick),
    .ns_red(ns_red), .ns_amber(ns_amber), .ns_green(ns_green),
    .ew_red(ew_red), .ew_amber(ew_amber), .ew_green(ew_green));

  traffic_cascade #(.W(16), .RED_T(16'(L_RED)), .GREEN_T(16'(L_GREEN)), .AMBER_T(16'(L_AMBER))) u_long (
    .clk(clk), .rst(rst_long), .tick(1'b1),
    .ns_red(l_ns_red), .ns_amber(l_ns_amber), .ns_green(l_ns_green),
    .ew_red(l_ew_red), .ew_amber(l_ew_amber), .ew_green(l_ew_green));

  int checks = 0;
  int errors = 0;
  bit main_done = 0;
  bit long_done = 0;
  bit reported = 0;

  logic [5:0] exp_q [$];
  string      tag_q [$];

  int m_phase = 0;
  int m_cnt = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int preset_of(input int p);
    return (p == 0) ? RED : (p == 1) ? GREEN : AMBER;
  endfunction

  // lamps {ns_red, ns_amber, ns_green, ew_red, ew_amber, ew_green}
  function automatic logic [5:0] model_lamps();
    case (m_phase)
      0: return (m_cnt < RED - AMBER) ? 6'b100_001 : 6'b100_010;
      1: return 6'b001_100;
      2: return 6'b010_100;
      default: return 6'b100_001;
    endcase
  endfunction

  task automatic step(input logic t, input logic r, input string tag);
    string tg;
    @(negedge clk);
    tick = t;
    rst = r;
    @(posedge clk);
    #1;
    if (r) begin
      m_phase = 0; m_cnt = 0;
    end else if (m_phase == 3) begin
      m_phase = 0; m_cnt = 0;
    end else if (t) begin
      m_cnt++;
      if (m_cnt == preset_of(m_phase)) begin
        m_phase = (m_phase == 2) ? 3 : m_phase + 1;
        m_cnt = 0;
      end
    end
    tg = r ? "R1" : (m_phase == 3) ? "R4" :
         (m_phase == 0 && m_cnt >= RED - AMBER) ? "R5" : tag;
    exp_q.push_back(model_lamps());
    tag_q.push_back(tg);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [5:0] e;
      logic [5:0] g;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      g = {ns_red, ns_amber, ns_green, ew_red, ew_amber, ew_green};
      check(g == e, tg, 32'(g), 32'(e));
      check($countones(g[5:3]) == 1 && $countones(g[2:0]) == 1 && (g[5] || g[2]),
            "R6", 32'(g), 32'(e));
    end
  end

  initial begin
    repeat (4) step(1'b1, 1'b1, "R1");
    for (int i = 0; i < 130; i++) step(1'b1, 1'b0, "R2");
    for (int i = 0; i < 200; i++) step((i % 3) == 2, 1'b0, "R3");
    for (int i = 0; i < 60; i++) step(1'b0, 1'b0, "R3");
    for (int i = 0; i < 400; i++) step(((i * 7) % 5) < 2, 1'b0, "R2");
    while (m_phase != 1) step(1'b1, 1'b0, "R2");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b1, "R1");
    for (int i = 0; i < 150; i++) step(1'b1, 1'b0, "R5");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R3");
    repeat (3) @(negedge clk);
    main_done = 1;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_long = 1'b0;
    n = 0;
    while (l_ns_red && n < L_RED + 10) begin
      if (n == L_RED - L_AMBER - 1) check(l_ew_green, "R7 ew green before switch", 32'(l_ew_green), 1);
      if (n == L_RED - L_AMBER) check(l_ew_amber, "R7 ew amber at switch", 32'(l_ew_amber), 1);
      n++;
      @(negedge clk);
    end
    check(n == L_RED, "R7 long red length", n, L_RED);
    n = 0;
    while (l_ns_green && n < L_GREEN + 10) begin n++; @(negedge clk); end
    check(n == L_GREEN, "R7 long green length", n, L_GREEN);
    n = 0;
    while (l_ns_amber && n < L_AMBER + 10) begin n++; @(negedge clk); end
    check(n == L_AMBER, "R2 long amber length", n, L_AMBER);
    check(l_ns_red && l_ew_green, "R4 restart lamps", 32'({l_ns_red, l_ew_green}), 3);
    long_done = 1;
  end

  initial begin
    fork
      begin wait (main_done && long_done); end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
      end
    join_any
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule